// File: doc/BRIEF.md
# Double-Buffered Timer-Based PWM Generator

This block drives a single pulse-width-modulated output with up to 10 bits of duty resolution. An 8-bit period timer counts up to a programmable period limit. A prescaler counter sits in front of it. The two lowest bits of a 10-bit time base are taken from that counter, and the timer count supplies the upper eight.

Software presents a 10-bit duty value as an 8-bit upper part and a 2-bit lower part. The block copies that value into a private shadow register only when a new period begins. A write that lands in the middle of a period therefore changes nothing until the next boundary.

The output is set at the start of every period. It is cleared when the time base reaches the shadow duty value. A zero duty value keeps the output low for the whole period. The block announces each period start with a one-cycle pulse.

Top module: `pwm_gen`

## Requirements
- R1: While `pwmEnable` is low, `pwmOut` and `periodMatch` are low and the time base is held at zero. In the first clock cycle after the edge that samples `pwmEnable` high, a new period begins and `periodMatch` is high.
- R2: The prescale select chooses the divide ratio: code 0 divides by 1, code 1 by 4, and codes 2 and 3 by 16. Consecutive `periodMatch` pulses are (periodLimit + 1) × 4 × divide clock cycles apart.
- R3: For a non-zero duty value, `pwmOut` is high in the same cycle in which `periodMatch` is high.
- R4: When the duty value D = {dutyUpper, dutyLower} satisfies 1 ≤ D ≤ 4 × periodLimit + 3, `pwmOut` is high for exactly D × divide cycles in each period. Those cycles form one unbroken run that starts at the period start.
- R5: A duty value of zero keeps `pwmOut` low for the entire period, including the period-start cycle.
- R6: When D > 4 × periodLimit + 3, `pwmOut` stays high for the whole period and has no falling edge inside it.
- R7: The duty value is sampled only at a period start. A change to `dutyUpper` or `dutyLower` in the middle of a period leaves that period's pulse unchanged and applies from the next period.
- R8: `periodMatch` is high for exactly one clock cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each cycle is one oscillator period |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwmEnable | input | 1 | Mode enable; low forces the output low and parks the timer |
| periodLimit | input | 8 | Last timer count of a period |
| dutyUpper | input | 8 | Upper eight bits of the duty value |
| dutyLower | input | 2 | Lower two bits of the duty value |
| prescaleSel | input | 2 | Prescale code: 0 is /1, 1 is /4, 2 and 3 are /16 |
| pwmOut | output | 1 | PWM output level |
| periodMatch | output | 1 | One-cycle pulse in the first cycle of each period |

## Verification
Two events can fall in the same cycle. The first is the period-start set. The second is the clear that fires when the time base equals the shadow duty value.

They coincide when the duty value is zero, because the time base is also zero at the start. They also meet at the other end of the range, where D sits at 4 × periodLimit + 3 or just above it. The bench sweeps every duty value from zero to two past that limit, for several period limits and every prescale code. For each period it compares the measured high time, the period length and the start-cycle level against arithmetic expectations.

A second collision pits a software duty write against a running period. The bench rewrites the duty value part-way through a period, both below and above the current time base. It then requires the old pulse width in that period, the new one in the next, and no second rising edge.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  // Strobes from the time-base control to the duty datapath.
  typedef struct packed {
    logic start;  // the coming edge opens a new period
    logic hold;   // block disabled: park everything
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_timebase_ctrl.sv
module pwm_timebase_ctrl
  import pwm_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int SUB_W  = 2,
  parameter int PS_LOG = 2,
  parameter int MAX_K  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [TMR_W-1:0]       periodLimit,
  input  logic [1:0]             prescaleSel,
  output pwmStrobe_t             strobe,
  output logic [TMR_W+SUB_W-1:0] timeBase,
  output logic                   periodMatch
);

  localparam int PRE_W = SUB_W + PS_LOG * MAX_K;

  logic [TMR_W-1:0] tmrQ;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preLast;
  logic [SUB_W-1:0] subBits;
  logic [1:0]       selK;
  logic             enQ;
  logic             tickEnd;
  logic             terminal;
  logic             startNow;

  assign selK = (int'(prescaleSel) > MAX_K) ? 2'(MAX_K) : prescaleSel;

  // The last prescaler count and the sub-count bits depend on the ratio.
  always_comb begin
    preLast = '0;
    subBits = '0;
    for (int k = 0; k <= MAX_K; k++) begin
      if (int'(selK) == k) begin
        preLast = {PRE_W{1'b1}} >> (PS_LOG * (MAX_K - k));
        subBits = preCnt[PS_LOG*k +: SUB_W];
      end
    end
  end

  assign tickEnd  = (preCnt >= preLast);
  assign terminal = (tmrQ == periodLimit) && tickEnd;
  assign startNow = enable && (!enQ || terminal);

  assign strobe.start = startNow;
  assign strobe.hold  = !enable;
  assign timeBase     = {tmrQ, subBits};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmrQ        <= '0;
      preCnt      <= '0;
      enQ         <= 1'b0;
      periodMatch <= 1'b0;
    end else if (!enable) begin
      tmrQ        <= '0;
      preCnt      <= '0;
      enQ         <= 1'b0;
      periodMatch <= 1'b0;
    end else begin
      enQ         <= 1'b1;
      periodMatch <= startNow;
      if (startNow) begin
        tmrQ   <= '0;
        preCnt <= '0;
      end else if (tickEnd) begin
        preCnt <= '0;
        tmrQ   <= tmrQ + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R8: a period-start pulse never lasts two cycles
  a_r8_match_single: assert property (@(posedge clk) disable iff (!rst_n)
    periodMatch |=> !periodMatch);

  // R1: a disabled block is silent and parked at time zero
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!periodMatch && timeBase == '0));

endmodule

// File: rtl/pwm_duty_path.sv
module pwm_duty_path
  import pwm_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pwmStrobe_t             strobe,
  input  logic [TMR_W+SUB_W-1:0] timeBase,
  input  logic [TMR_W-1:0]       dutyUpper,
  input  logic [SUB_W-1:0]       dutyLower,
  output logic                   pwmOut
);

  localparam int DUTY_W = TMR_W + SUB_W;

  logic [DUTY_W-1:0] swDuty;
  logic [DUTY_W-1:0] shadowDuty;
  logic              outLatch;
  logic              dutyHit;

  assign swDuty  = {dutyUpper, dutyLower};
  assign dutyHit = (timeBase == shadowDuty);

  // Set/reset latch: the period start sets it, a duty match resets it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowDuty <= '0;
      outLatch   <= 1'b0;
    end else if (strobe.hold) begin
      outLatch <= 1'b0;
    end else if (strobe.start) begin
      shadowDuty <= swDuty;
      outLatch   <= |swDuty;
    end else if (dutyHit) begin
      outLatch <= 1'b0;
    end
  end

  assign pwmOut = outLatch && !dutyHit;

  // R7: the shadow duty only changes at a period start
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.start |=> $stable(shadowDuty));

  // R5: zero duty never raises the output at a period start
  a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.start && swDuty == '0) |=> !pwmOut);

  // R4: the output only rises on the cycle after a period start
  a_r4_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwmOut) |-> $past(strobe.start));

  // R1: disabling drops the output
  a_r1_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.hold |=> !pwmOut);

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int SUB_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwmEnable,
  input  logic [TMR_W-1:0] periodLimit,
  input  logic [TMR_W-1:0] dutyUpper,
  input  logic [SUB_W-1:0] dutyLower,
  input  logic [1:0]       prescaleSel,
  output logic             pwmOut,
  output logic             periodMatch
);

  pwmStrobe_t             strobe;
  logic [TMR_W+SUB_W-1:0] timeBase;

  pwm_timebase_ctrl #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (pwmEnable),
    .periodLimit (periodLimit),
    .prescaleSel (prescaleSel),
    .strobe      (strobe),
    .timeBase    (timeBase),
    .periodMatch (periodMatch)
  );

  pwm_duty_path #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .timeBase  (timeBase),
    .dutyUpper (dutyUpper),
    .dutyLower (dutyLower),
    .pwmOut    (pwmOut)
  );

endmodule

// File: tb/sim_pwm_gen.sv
module sim_pwm_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwmEnable = 1'b0;
  logic [7:0] periodLimit = '0;
  logic [7:0] dutyUpper = '0;
  logic [1:0] dutyLower = '0;
  logic [1:0] prescaleSel = '0;
  logic       pwmOut;
  logic       periodMatch;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;  // 250 MHz

  pwm_gen u0 (
    .clk(clk), .rst_n(rst_n), .pwmEnable(pwmEnable), .periodLimit(periodLimit),
    .dutyUpper(dutyUpper), .dutyLower(dutyLower), .prescaleSel(prescaleSel),
    .pwmOut(pwmOut), .periodMatch(periodMatch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Waits for the next period start and measures that period. A duty write
  // of chgVal is made after chgAt cycles of it (never, when chgAt is 0).
  task automatic measurePeriod(input int chgAt, input logic [9:0] chgVal,
                               output int len, output int hi,
                               output bit glitch, output bit firstHi);
    bit sawLow = 0;
    int guard = 0;
    @(negedge clk);
    while (!periodMatch && guard < 100000) begin
      @(negedge clk);
      guard++;
    end
    firstHi = pwmOut;
    len = 0;
    hi = 0;
    glitch = 0;
    do begin
      if (pwmOut) begin
        hi++;
        if (sawLow) glitch = 1;
      end else begin
        sawLow = 1;
      end
      len++;
      if (len == chgAt) {dutyUpper, dutyLower} = chgVal;
      @(negedge clk);
    end while (!periodMatch && len < 100000);
  endtask

  task automatic reconfigure(input int pr, input int ps);
    pwmEnable = 1'b0;
    @(negedge clk);
    chk(!pwmOut && !periodMatch, "R1 disabled quiet", int'(pwmOut), 0);
    periodLimit = 8'(pr);
    prescaleSel = 2'(ps);
    @(negedge clk);
    @(negedge clk);
    chk(!pwmOut && !periodMatch, "R1 still quiet", int'(periodMatch), 0);
    pwmEnable = 1'b1;
    @(negedge clk);
    chk(periodMatch == 1'b1, "R1 start after enable", int'(periodMatch), 1);
  endtask

  initial begin
    #(4 * 190000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int prList[4] = '{0, 1, 2, 5};
    int len, hi, expLen, expHi, div;
    bit glitch, firstHi;

    repeat (3) @(negedge clk);
    chk(!pwmOut && !periodMatch, "R1 reset state", int'(pwmOut), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pwmOut && !periodMatch, "R1 idle after reset", int'(periodMatch), 0);

    // Sweep every duty value around the full range, for each ratio and
    // a few period limits. Code 3 is checked once, below.
    for (int ps = 0; ps < 3; ps++) begin
      div = 1 << (2 * ps);
      foreach (prList[i]) begin
        reconfigure(prList[i], ps);
        expLen = (prList[i] + 1) * 4 * div;
        for (int d = 0; d <= 4 * prList[i] + 5; d++) begin
          {dutyUpper, dutyLower} = 10'(d);
          measurePeriod(0, '0, len, hi, glitch, firstHi);
          if (d == 0) expHi = 0;
          else if (d > 4 * prList[i] + 3) expHi = expLen;
          else expHi = d * div;
          chk(len == expLen, "R2 period length", len, expLen);
          chk(len > 1, "R8 single match pulse", len, expLen);
          chk(hi == expHi, (d == 0) ? "R5 zero duty" :
              (d > 4 * prList[i] + 3) ? "R6 over-range duty" : "R4 high time",
              hi, expHi);
          chk(firstHi == (d != 0), "R3 start level", int'(firstHi), int'(d != 0));
          chk(!glitch, "R4 single high run", int'(glitch), 0);
        end
      end
    end

    // Code 3 also selects divide-by-16 (R2).
    reconfigure(1, 3);
    {dutyUpper, dutyLower} = 10'd5;
    measurePeriod(0, '0, len, hi, glitch, firstHi);
    chk(len == 128, "R2 code 3 length", len, 128);
    chk(hi == 80, "R4 code 3 high time", hi, 80);

    // R7: mid-period writes wait for the next boundary.
    reconfigure(5, 0);
    {dutyUpper, dutyLower} = 10'd10;
    measurePeriod(0, '0, len, hi, glitch, firstHi);
    chk(hi == 10, "R7 baseline", hi, 10);
    measurePeriod(6, 10'd3, len, hi, glitch, firstHi);
    chk(hi == 10 && !glitch, "R7 lower write mid-period", hi, 10);
    measurePeriod(2, 10'd20, len, hi, glitch, firstHi);
    chk(hi == 3 && !glitch, "R7 applied next period", hi, 3);
    measurePeriod(0, '0, len, hi, glitch, firstHi);
    chk(hi == 20 && !glitch, "R7 raised write applied", hi, 20);
    measurePeriod(4, 10'd0, len, hi, glitch, firstHi);
    chk(hi == 20, "R7 zero write deferred", hi, 20);
    measurePeriod(0, '0, len, hi, glitch, firstHi);
    chk(hi == 0 && !firstHi, "R5 zero after deferral", hi, 0);

    pwmEnable = 1'b0;
    @(negedge clk);
    chk(!pwmOut, "R1 final disable", int'(pwmOut), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule